// File: doc/BRIEF.md
# Trapezoid Matching-Degree Unit

This unit takes two trapezoidal fuzzy sets on a 64-point universe and returns how strongly they agree. One set is the antecedent of a rule. The other is a fuzzified measurement. The answer is a 4-bit grade, where 0 means no agreement and 15 means full agreement.

The unit never walks the universe point by point. It compares the eight breakpoints to sort the pair into one of four classes. Only when the two sets overlap on a sloping edge does it compute a height: it scales the edge difference by 15 with a shift and a subtract, then divides by the sum of the two slope widths.

Pairs enter and results leave on valid/ready streams. A pair is accepted on any rising edge where `in_valid` and `in_ready` are both high. A result is consumed on any rising edge where `out_valid` and `out_ready` are both high. `in_ready` may depend combinationally on `out_ready`. A result that is not taken stays on the output, unchanged. The source may drop `in_valid` at any time. The unit is a two-stage pipeline: classification and edge differences in the first stage, then division and the output mux in the second. When the sink keeps `out_ready` high, it accepts one pair per cycle.

Top module: `trap_match`

## Requirements
- R1: After reset is released, `out_valid` is 0 and `in_ready` is 1 until a pair has been accepted.
- R2: Breakpoint 1 (left foot) through breakpoint 4 (right foot) sit in elements 0 to 3 of `in_a` and `in_x`. When the two sets are identical in all four elements, the grade is 15 and `out_case` is 2'b00.
- R3: When a[3] <= x[0] or x[3] <= a[0] (the supports only touch or are apart), the grade is 0 and `out_case` is 2'b11.
- R4: When a[2] < x[1] and x[0] < a[3], the grade is floor(15*(a[3]-x[0]) / ((a[3]-a[2]) + (x[1]-x[0]))), limited to 15, and `out_case` is 2'b01.
- R5: When x[2] < a[1] and a[0] < x[3], the grade is floor(15*(x[3]-a[0]) / ((x[3]-x[2]) + (a[1]-a[0]))), limited to 15, and `out_case` is 2'b10.
- R6: Any ordered pair that falls in none of the classes of R2 to R5 has overlapping flat tops. It gets grade 15 and `out_case` 2'b00.
- R7: The classes are tested in the order identical, apart, right overlap, left overlap. A single-point set matched against itself therefore gives 15, not 0.
- R8: `out_case` always carries the class code that goes with the reported grade: 00 full, 01 right edge, 10 left edge, 11 none.
- R9: A pair accepted on edge k shows its result with `out_valid` high after edge k+1, provided the output stage was empty or drained at k+1.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_grade` and `out_case` stay unchanged on the next cycle.
- R11: Results leave in the order the pairs were accepted, and each pair gives exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Unit can take a pair this cycle |
| in_a | input | 4 x PT_W | Antecedent breakpoints, element 0 leftmost |
| in_x | input | 4 x PT_W | Fuzzified input breakpoints, element 0 leftmost |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_grade | output | GR_W | Matching degree, 0 to 2^GR_W-1 |
| out_case | output | 2 | Class code of the result |

## Verification
The properties assume that each trapezoid arrives with its breakpoints in non-decreasing order. Under that assumption, R4 and R5 can never produce a zero divisor or a ratio above one, and every unclassified pair has overlapping flat tops. The stimulus respects this. The sweep builds every non-decreasing quadruple over six evenly spaced points of the universe and pairs each one with every other. The directed pairs that reach the ends of the universe are also written in order. Both the arrival of inputs and the readiness of the sink follow irregular patterns, so the pipeline stalls and bubbles while these checks run.

// File: rtl/trap_match_pkg.sv
`timescale 1ns/1ps
package trap_match_pkg;
  typedef enum logic [1:0] {
    MC_FULL  = 2'b00,
    MC_RIGHT = 2'b01,
    MC_LEFT  = 2'b10,
    MC_NONE  = 2'b11
  } match_case_e;
endpackage

// File: rtl/trap_edge_div.sv
`timescale 1ns/1ps
// Unrolled restoring divider: one compare/subtract row per dividend bit.
module trap_edge_div #(
  parameter int N_W = 10,
  parameter int D_W = 7
) (
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quotient,
  output logic [D_W-1:0] remainder
);
  logic [D_W-1:0] part [0:N_W];

  assign part[0] = '0;

  for (genvar j = 0; j < N_W; j++) begin : g_row
    logic [D_W:0]   trial;
    logic [D_W-1:0] diff;
    logic           take;
    assign trial = {part[j], dividend[N_W-1-j]};
    assign take  = trial >= {1'b0, divisor};
    assign diff  = trial[D_W-1:0] - divisor;
    assign quotient[N_W-1-j] = take;
    assign part[j+1] = take ? diff : trial[D_W-1:0];
  end

  assign remainder = part[N_W];
endmodule

// File: rtl/trap_classify.sv
`timescale 1ns/1ps
// Breakpoint comparator: class code plus numerator/denominator of the crossing height.
module trap_classify
  import trap_match_pkg::*;
#(
  parameter int PT_W = 6
) (
  input  logic [3:0][PT_W-1:0] pa,
  input  logic [3:0][PT_W-1:0] px,
  output match_case_e          kind,
  output logic [PT_W-1:0]      num,
  output logic [PT_W:0]        den
);
  logic same, apart, right_ov, left_ov;
  logic [PT_W-1:0] a_fall, x_rise, x_fall, a_rise;

  assign same     = (pa == px);
  assign apart    = (pa[3] <= px[0]) || (px[3] <= pa[0]);
  assign right_ov = (pa[2] < px[1]) && (px[0] < pa[3]);
  assign left_ov  = (px[2] < pa[1]) && (pa[0] < px[3]);

  assign a_fall = pa[3] - pa[2];
  assign x_rise = px[1] - px[0];
  assign x_fall = px[3] - px[2];
  assign a_rise = pa[1] - pa[0];

  always_comb begin
    kind = MC_FULL;
    num  = '0;
    den  = '0;
    if (same) begin
      kind = MC_FULL;
    end else if (apart) begin
      kind = MC_NONE;
    end else if (right_ov) begin
      kind = MC_RIGHT;
      num  = pa[3] - px[0];
      den  = {1'b0, a_fall} + {1'b0, x_rise};
    end else if (left_ov) begin
      kind = MC_LEFT;
      num  = px[3] - pa[0];
      den  = {1'b0, x_fall} + {1'b0, a_rise};
    end
  end
endmodule

// File: rtl/trap_grade_calc.sv
`timescale 1ns/1ps
// Crossing height: (num*GMAX)/den, scaled by shift-and-subtract, saturated.
module trap_grade_calc #(
  parameter int PT_W = 6,
  parameter int GR_W = 4
) (
  input  logic [PT_W-1:0] num,
  input  logic [PT_W:0]   den,
  output logic [GR_W-1:0] grade
);
  localparam int P_W  = PT_W + GR_W;
  localparam int D_W  = PT_W + 1;
  localparam logic [GR_W-1:0] GMAX = '1;

  logic [P_W-1:0] num_ext, scaled, quot;
  logic [D_W-1:0] rem;

  assign num_ext = {{GR_W{1'b0}}, num};
  assign scaled  = (num_ext << GR_W) - num_ext;

  trap_edge_div #(.N_W(P_W), .D_W(D_W)) u_div (
    .dividend (scaled),
    .divisor  (den),
    .quotient (quot),
    .remainder(rem)
  );

  always_comb begin
    if (den == '0 || quot > P_W'(GMAX)) grade = GMAX;
    else                                grade = quot[GR_W-1:0];
  end

  always_comb begin
    if (den != '0) begin
      p_rem_bound_r4: assert (rem < den);
    end
  end
endmodule

// File: rtl/trap_match.sv
`timescale 1ns/1ps
module trap_match
  import trap_match_pkg::*;
#(
  parameter int PT_W = 6,
  parameter int GR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0][PT_W-1:0] in_a,
  input  logic [3:0][PT_W-1:0] in_x,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [GR_W-1:0]      out_grade,
  output logic [1:0]           out_case
);
  localparam logic [GR_W-1:0] GMAX = '1;

  match_case_e     c_kind, s1_kind;
  logic [PT_W-1:0] c_num, s1_num;
  logic [PT_W:0]   c_den, s1_den;
  logic [GR_W-1:0] edge_grade, sel_grade;
  logic            s1_v, s2_v, s2_load, s1_adv;

  trap_classify #(.PT_W(PT_W)) u_cls (
    .pa  (in_a),
    .px  (in_x),
    .kind(c_kind),
    .num (c_num),
    .den (c_den)
  );

  assign s2_load  = !s2_v || out_ready;
  assign s1_adv   = !s1_v || s2_load;
  assign in_ready = s1_adv;

  // Phase 1: register class and edge terms.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_kind <= MC_NONE;
      s1_num  <= '0;
      s1_den  <= '0;
    end else if (s1_adv) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_kind <= c_kind;
        s1_num  <= c_num;
        s1_den  <= c_den;
      end
    end
  end

  trap_grade_calc #(.PT_W(PT_W), .GR_W(GR_W)) u_calc (
    .num  (s1_num),
    .den  (s1_den),
    .grade(edge_grade)
  );

  always_comb begin
    unique case (s1_kind)
      MC_FULL:  sel_grade = GMAX;
      MC_NONE:  sel_grade = '0;
      default:  sel_grade = edge_grade;
    endcase
  end

  // Phase 2: divide, select, register the result.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v      <= 1'b0;
      out_grade <= '0;
      out_case  <= 2'b00;
    end else if (s2_load) begin
      s2_v <= s1_v;
      if (s1_v) begin
        out_grade <= sel_grade;
        out_case  <= s1_kind;
      end
    end
  end

  assign out_valid = s2_v;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_grade) && $stable(out_case)));

  p_none_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_case == 2'b11) |-> (out_grade == '0));

  p_full_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_case == 2'b00) |-> (out_grade == GMAX));

  p_two_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);
endmodule

// File: tb/tb_trap_match.sv
`timescale 1ns/1ps
module tb_trap_match;
  localparam int PT_W = 6;
  localparam int GR_W = 4;
  localparam int N_DIR = 8;
  localparam int N_QUAD = 126;
  localparam int N_TOTAL = N_DIR + N_QUAD * N_QUAD;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [3:0][PT_W-1:0] in_a, in_x;
  logic [GR_W-1:0] out_grade;
  logic [1:0] out_case;

  trap_match #(.PT_W(PT_W), .GR_W(GR_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_x(in_x), .out_valid(out_valid), .out_ready(out_ready),
    .out_grade(out_grade), .out_case(out_case)
  );

  int tests = 0;
  int fails = 0;
  int quads [N_QUAD][4];
  int expq [$];
  int sent = 0;
  int recv = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements: grade | case<<4 | tag<<6
  function automatic int model(input logic [3:0][PT_W-1:0] a,
                               input logic [3:0][PT_W-1:0] x);
    int a1 = a[0], a2 = a[1], a3 = a[2], a4 = a[3];
    int x1 = x[0], x2 = x[1], x3 = x[2], x4 = x[3];
    int g, c, t, den;
    if (a == x) begin
      g = 15; c = 0; t = (a1 == a4) ? 7 : 2;
    end else if (a4 <= x1 || x4 <= a1) begin
      g = 0; c = 3; t = 3;
    end else if (a3 < x2 && x1 < a4) begin
      den = (a4 - a3) + (x2 - x1);
      g = (den == 0) ? 15 : (15 * (a4 - x1)) / den;
      if (g > 15) g = 15;
      c = 1; t = 4;
    end else if (x3 < a2 && a1 < x4) begin
      den = (x4 - x3) + (a2 - a1);
      g = (den == 0) ? 15 : (15 * (x4 - a1)) / den;
      if (g > 15) g = 15;
      c = 2; t = 5;
    end else begin
      g = 15; c = 0; t = 6;
    end
    return g | (c << 4) | (t << 6);
  endfunction

  function automatic logic [3:0][PT_W-1:0] mk(input int p0, input int p1,
                                              input int p2, input int p3);
    logic [3:0][PT_W-1:0] r;
    r[0] = PT_W'(p0); r[1] = PT_W'(p1); r[2] = PT_W'(p2); r[3] = PT_W'(p3);
    return r;
  endfunction

  task automatic get_item(input int k, output logic [3:0][PT_W-1:0] a,
                          output logic [3:0][PT_W-1:0] x);
    int j;
    case (k)
      0: begin a = mk(5, 10, 20, 30);  x = mk(5, 10, 20, 30);  end // R2
      1: begin a = mk(30, 30, 30, 30); x = mk(30, 30, 30, 30); end // R7
      2: begin a = mk(0, 10, 20, 25);  x = mk(25, 30, 40, 50); end // R3 touching
      3: begin a = mk(0, 10, 20, 40);  x = mk(30, 45, 55, 63); end // R4
      4: begin a = mk(30, 45, 55, 63); x = mk(0, 10, 20, 40);  end // R5
      5: begin a = mk(0, 5, 60, 63);   x = mk(20, 25, 30, 35); end // R6 nested
      6: begin a = mk(0, 0, 0, 63);    x = mk(0, 63, 63, 63);  end // R4 full span
      7: begin a = mk(0, 63, 63, 63);  x = mk(0, 0, 0, 63);    end // R5 full span
      default: begin
        j = k - N_DIR;
        a = mk(quads[j / N_QUAD][0], quads[j / N_QUAD][1],
               quads[j / N_QUAD][2], quads[j / N_QUAD][3]);
        x = mk(quads[j % N_QUAD][0], quads[j % N_QUAD][1],
               quads[j % N_QUAD][2], quads[j % N_QUAD][3]);
      end
    endcase
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R9 watchdog: actual %0d results, expected %0d", recv, N_TOTAL + 1);
    summary();
    $finish;
  end

  initial begin
    int n, ptr, cyc, e, hg, hc;
    bit hold;
    logic [3:0][PT_W-1:0] a, x;

    n = 0;
    for (int p0 = 0; p0 < 6; p0++)
      for (int p1 = p0; p1 < 6; p1++)
        for (int p2 = p1; p2 < 6; p2++)
          for (int p3 = p2; p3 < 6; p3++) begin
            quads[n][0] = p0 * 9; quads[n][1] = p1 * 9;
            quads[n][2] = p2 * 9; quads[n][3] = p3 * 9;
            n++;
          end

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_x = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    ptr = 0; cyc = 0; hold = 0; hg = 0; hc = 0;
    while (ptr < N_TOTAL || expq.size() > 0) begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
      if (ptr < N_TOTAL && (cyc % 13) != 0) begin
        get_item(ptr, a, x);
        in_a = a; in_x = x; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (hold) begin
        check(out_valid == 1'b1, "R10", "valid held under stall", out_valid, 1);
        check(out_grade == hg && out_case == hc, "R10", "grade/case held under stall",
              {out_case, out_grade}, (hc << 4) | hg);
      end
      hold = out_valid && !out_ready;
      hg = out_grade; hc = out_case;
      if (out_valid && out_ready) begin
        recv++;
        if (expq.size() == 0) begin
          check(1'b0, "R11", "result without accepted pair", recv, sent);
        end else begin
          e = expq.pop_front();
          check(out_grade == (e & 15), $sformatf("R%0d", e >> 6), "grade",
                out_grade, e & 15);
          check(out_case == ((e >> 4) & 3), "R8", "class code", out_case, (e >> 4) & 3);
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(in_a, in_x));
        sent++;
        ptr++;
      end
    end
    in_valid = 1'b0;

    // Latency with an idle pipeline and a ready sink
    @(negedge clk);
    out_ready = 1'b1;
    in_a = mk(0, 10, 20, 40); in_x = mk(30, 45, 55, 63);
    in_valid = 1'b1;
    #1;
    check(in_ready == 1'b1, "R9", "in_ready on idle pipe", in_ready, 1);
    e = model(in_a, in_x);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9", "no result one edge after accept", out_valid, 0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9", "result two edges after accept", out_valid, 1);
    check(out_grade == (e & 15), "R9", "grade at two-edge point", out_grade, e & 15);
    if (out_valid) recv++;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11", "single result per pair", out_valid, 0);
    check(recv == sent, "R11", "results equal accepted pairs", recv, sent);

    summary();
    $finish;
  end
endmodule